// File: doc/BRIEF.md
# Segment-Relocating Prefetch Bus Unit

This unit sits between the execution side of a small byte-wide processor and a simple synchronous memory port. It turns 16-bit segment and 16-bit offset pairs into 20-bit physical byte addresses. It shifts the segment left by four bits, adds the offset, and drops any carry out of bit 19. While the execution side is busy, the unit fetches instruction bytes ahead of use from the code segment into a four-byte queue. The execution side takes the oldest byte through a valid/accept handshake.

The execution side may also ask for a single-byte operand read or write. It gives an unrelocated offset and a segment selector, and it holds the request until it sees the done pulse. Operand accesses win over prefetching. A redirect input empties the queue and restarts fetching at a new code-segment offset. After reset, fetching starts at physical address FFFF0h.

Control is a three-state machine. IDLE issues nothing. FETCH holds a prefetch read on the bus. OPER holds an operand access on the bus. The transitions are:
- IDLE→IDLE on redirect, or when no operand is pending and the queue is full.
- IDLE→OPER when an operand is pending.
- IDLE→FETCH when the queue has room.
- FETCH→IDLE when the memory is ready, or on redirect (the prefetch is abandoned).
- FETCH→FETCH while waiting.
- OPER→IDLE when the memory is ready.
- OPER→OPER while waiting.

Top module: `seg_prefetch_biu`

## Requirements
- R1: A physical address equals segment×16 plus the zero-extended offset, taken modulo 2^20. For example, segment FFFFh with offset 0010h gives 00000h.
- R2: Reset leaves the queue empty (`ib_valid`=0) and the bus idle. The first bus request then comes one cycle after reset release, and it is a read of FFFF0h.
- R3: Prefetch offsets step by one from the current code offset. They wrap from FFFFh to 0000h inside the same segment, so segment 1000h gives 1FFFFh and then 10000h.
- R4: The queue holds at most 4 bytes. No prefetch is started while it is full and no operand is pending.
- R5: Bytes appear on `ib_byte` in fetch order while `ib_valid`=1. Each clock edge with `ib_accept`=1 removes the oldest byte, and a removal and an append may happen at the same edge.
- R6: A redirect empties the queue, so `ib_valid`=0 in the next cycle. It abandons a prefetch that is in flight, so its byte never reaches the queue. The next prefetch reads `cs_seg`:`redirect_ip` as sampled with the redirect.
- R7: The operand segment is chosen by `op_sel`: 0 = extra, 1 = code, 2 = stack, 3 = data. The operand address is relocated as in R1.
- R8: An operand request is issued at the first idle cycle. At most the one prefetch already on the bus finishes before it, even when the queue has room.
- R9: `op_done` is high in the cycle the operand access meets `mem_ready`. A read returns `mem_rdata` on `op_rdata` in that cycle. A write drives `mem_we`=1 and `mem_wdata`=`op_wdata`.
- R10: Once `mem_req` is raised, it stays high with a stable `mem_addr` and `mem_we` until `mem_ready`. The one exception is a prefetch dropped by redirect.
- R11: Every completed transfer returns the unit to IDLE for one cycle before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_seg | input | 16 | Code segment value |
| ds_seg | input | 16 | Data segment value |
| es_seg | input | 16 | Extra segment value |
| ss_seg | input | 16 | Stack segment value |
| redirect | input | 1 | Flush queue and restart fetching |
| redirect_ip | input | 16 | New code offset used with redirect |
| ib_valid | output | 1 | Queue holds at least one byte |
| ib_byte | output | 8 | Oldest queued instruction byte |
| ib_accept | input | 1 | Execution side takes the oldest byte |
| op_req | input | 1 | Operand access pending (held until done) |
| op_we | input | 1 | Operand access is a write |
| op_sel | input | 2 | Operand segment selector |
| op_ofs | input | 16 | Unrelocated operand offset |
| op_wdata | input | 8 | Operand write byte |
| op_done | output | 1 | Operand access completes this cycle |
| op_rdata | output | 8 | Operand read byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory completes the transfer at this edge |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ready |

## Verification
The first request appears one cycle after reset release. A redirect empties the queue by the next cycle. Each transfer takes one IDLE cycle plus the memory latency plus one cycle, and `op_done` rises combinationally in the cycle `mem_ready` is high. The bench drives and samples two nanoseconds after each falling edge and checks these outputs in exactly the cycle they are due. It varies the memory latency between 0 and 3 cycles. Where a result depends on latency, the bench waits for the handshake and then checks the count of prefetches finished in between.

// File: rtl/seg_biu_pkg.sv
package seg_biu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_OPER  = 2'd2
    } biu_state_e;

    typedef enum logic [1:0] {
        SEL_EXTRA = 2'd0,
        SEL_CODE  = 2'd1,
        SEL_STACK = 2'd2,
        SEL_DATA  = 2'd3
    } seg_sel_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 20
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] phys
);
    localparam int BASE_W = SEG_W + SHIFT;
    localparam int SUM_W  = (BASE_W > OFS_W) ? BASE_W + 1 : OFS_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum  = SUM_W'({seg, {SHIFT{1'b0}}}) + SUM_W'(ofs);
        phys = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/seg_byte_queue.sv
module seg_byte_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DATA_W-1:0]          din,
    input  logic                       pop,
    output logic [DATA_W-1:0]          dout,
    output logic                       valid,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign valid   = (count != '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign dout    = slot[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && valid;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot[i] <= '0;
                else if (do_push && !flush && wr_ptr == PTR_W'(i))
                    slot[i] <= din;
            end
        end
    endgenerate
endmodule

// File: rtl/seg_biu_fsm.sv
module seg_biu_fsm
    import seg_biu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       redirect,
    input  logic       op_req,
    input  logic       q_full,
    input  logic       mem_ready,
    output biu_state_e state_q,
    output logic       fetch_on,
    output logic       oper_on
);
    biu_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (redirect)     state_d = ST_IDLE;
                else if (op_req)  state_d = ST_OPER;
                else if (!q_full) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (redirect || mem_ready) state_d = ST_IDLE;
            end
            ST_OPER: begin
                if (mem_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fetch_on = 1'b0;
        oper_on  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: fetch_on = 1'b1;
            ST_OPER:  oper_on  = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/seg_prefetch_biu.sv
module seg_prefetch_biu
    import seg_biu_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SHIFT     = 4,
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int Q_DEPTH   = 4,
    parameter logic [SEG_W-1:0] BOOT_SEG = '1,
    parameter logic [OFS_W-1:0] BOOT_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  cs_seg,
    input  logic [SEG_W-1:0]  ds_seg,
    input  logic [SEG_W-1:0]  es_seg,
    input  logic [SEG_W-1:0]  ss_seg,
    input  logic              redirect,
    input  logic [OFS_W-1:0]  redirect_ip,
    output logic              ib_valid,
    output logic [DATA_W-1:0] ib_byte,
    input  logic              ib_accept,
    input  logic              op_req,
    input  logic              op_we,
    input  logic [1:0]        op_sel,
    input  logic [OFS_W-1:0]  op_ofs,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              op_done,
    output logic [DATA_W-1:0] op_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int CNT_W = $clog2(Q_DEPTH + 1);

    biu_state_e        state_q;
    logic              fetch_on, oper_on, q_full, q_push, q_pop;
    logic [CNT_W-1:0]  q_count;
    logic [SEG_W-1:0]  fetch_seg, op_seg;
    logic [OFS_W-1:0]  fetch_ofs;
    logic [ADDR_W-1:0] fetch_phys, op_phys;

    // fetch pointer: boot vector after reset, reloaded by redirect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_seg <= BOOT_SEG;
            fetch_ofs <= BOOT_OFS;
        end else if (redirect) begin
            fetch_seg <= cs_seg;
            fetch_ofs <= redirect_ip;
        end else if (q_push) begin
            fetch_ofs <= fetch_ofs + 1'b1;
        end
    end

    always_comb begin
        unique case (seg_sel_e'(op_sel))
            SEL_EXTRA: op_seg = es_seg;
            SEL_CODE:  op_seg = cs_seg;
            SEL_STACK: op_seg = ss_seg;
            SEL_DATA:  op_seg = ds_seg;
            default:   op_seg = ds_seg;
        endcase
    end

    seg_addr_gen #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_fetch_ag (
        .seg  (fetch_seg),
        .ofs  (fetch_ofs),
        .phys (fetch_phys)
    );

    seg_addr_gen #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_op_ag (
        .seg  (op_seg),
        .ofs  (op_ofs),
        .phys (op_phys)
    );

    seg_biu_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .redirect  (redirect),
        .op_req    (op_req),
        .q_full    (q_full),
        .mem_ready (mem_ready),
        .state_q   (state_q),
        .fetch_on  (fetch_on),
        .oper_on   (oper_on)
    );

    assign q_push = fetch_on && mem_ready && !redirect;
    assign q_pop  = ib_accept;

    seg_byte_queue #(.DATA_W(DATA_W), .DEPTH(Q_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (redirect),
        .push  (q_push),
        .din   (mem_rdata),
        .pop   (q_pop),
        .dout  (ib_byte),
        .valid (ib_valid),
        .full  (q_full),
        .count (q_count)
    );

    assign mem_req   = fetch_on || oper_on;
    assign mem_we    = oper_on && op_we;
    assign mem_addr  = oper_on ? op_phys : fetch_phys;
    assign mem_wdata = (oper_on && op_we) ? op_wdata : '0;
    assign op_done   = oper_on && mem_ready;
    assign op_rdata  = mem_rdata;
endmodule

// File: rtl/seg_biu_chk.sv
module seg_biu_chk
    import seg_biu_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int Q_DEPTH = 4,
    parameter int CNT_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redirect,
    input logic              op_req,
    input logic              op_done,
    input logic              ib_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  q_count,
    input biu_state_e        state_q
);
    // R4
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(Q_DEPTH));

    // R4
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && q_count == CNT_W'(Q_DEPTH) && !op_req && !redirect) |=> !mem_req);

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !ib_valid);

    // R6
    drop_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && redirect) |=> !mem_req);

    // R8
    oper_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_req && !redirect) |=> (mem_req && state_q == ST_OPER));

    // R9
    done_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (mem_req && mem_ready));

    // R10
    hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !redirect) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11
    back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (state_q == ST_IDLE && !mem_req));
endmodule

bind seg_prefetch_biu seg_biu_chk #(.ADDR_W(ADDR_W), .Q_DEPTH(Q_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .redirect  (redirect),
    .op_req    (op_req),
    .op_done   (op_done),
    .ib_valid  (ib_valid),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .q_count   (q_count),
    .state_q   (state_q)
);

// File: tb/seg_prefetch_biu_bench.sv
module seg_prefetch_biu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cs_seg = 16'h0000, ds_seg = 16'h2345, es_seg = 16'hABCD, ss_seg = 16'hFFFF;
    logic        redirect = 1'b0;
    logic [15:0] redirect_ip = 16'h0000;
    logic        ib_valid, ib_accept = 1'b0;
    logic [7:0]  ib_byte;
    logic        op_req = 1'b0, op_we = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [15:0] op_ofs = 16'h0000;
    logic [7:0]  op_wdata = 8'h00;
    logic        op_done;
    logic [7:0]  op_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_chk = 0, n_bad = 0;
    int lat = 0, wcnt = 0, pf_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    seg_prefetch_biu u_seg_prefetch_biu (
        .clk(clk), .rst_n(rst_n), .cs_seg(cs_seg), .ds_seg(ds_seg), .es_seg(es_seg), .ss_seg(ss_seg),
        .redirect(redirect), .redirect_ip(redirect_ip), .ib_valid(ib_valid), .ib_byte(ib_byte),
        .ib_accept(ib_accept), .op_req(op_req), .op_we(op_we), .op_sel(op_sel), .op_ofs(op_ofs),
        .op_wdata(op_wdata), .op_done(op_done), .op_rdata(op_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
    endfunction

    function automatic logic [19:0] reloc(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] t;
        t = {1'b0, s, 4'h0} + {5'h00, o};
        return t[19:0];
    endfunction

    // memory model: ready after lat waiting cycles
    always_comb begin
        mem_ready = mem_req && (wcnt == lat);
        mem_rdata = pat(mem_addr);
    end

    always @(posedge clk) begin
        if (!mem_req || mem_ready) wcnt <= 0;
        else                       wcnt <= wcnt + 1;
        if (mem_req && mem_ready && !op_done) pf_cnt <= pf_cnt + 1;
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drain(input logic [15:0] s, input logic [15:0] o, input int n, input string req);
        int k = 0;
        for (int g = 0; g < 2000 && k < n; g++) begin
            tick();
            if (ib_valid) begin
                logic [7:0] e;
                e = pat(reloc(s, o + 16'(k)));
                chk(ib_byte == e, req, "queued byte", ib_byte, e);
                ib_accept = 1'b1;
                k++;
            end else begin
                ib_accept = 1'b0;
            end
        end
        tick();
        ib_accept = 1'b0;
        chk(k == n, req, "bytes drained", k, n);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        // R2: release visible, nothing issued yet
        chk(ib_valid == 1'b0, "R2", "ib_valid after reset", ib_valid, 0);
        chk(mem_req == 1'b0, "R2", "mem_req after reset", mem_req, 0);
        tick();
        chk(mem_req == 1'b1 && mem_we == 1'b0, "R2", "first fetch request", {mem_req, mem_we}, 2'b10);
        chk(mem_addr == 20'hFFFF0, "R2", "boot fetch address", mem_addr, 20'hFFFF0);
    endtask

    task automatic t_fill();
        // lat 0: two cycles per byte; four bytes after eight edges
        repeat (12) tick();
        chk(mem_req == 1'b0, "R4", "no fetch when full", mem_req, 0);
        chk(ib_valid == 1'b1, "R4", "queue valid", ib_valid, 1);
        chk(ib_byte == pat(20'hFFFF0), "R5", "oldest byte", ib_byte, pat(20'hFFFF0));
        repeat (5) tick();
        chk(mem_req == 1'b0, "R4", "still stalled", mem_req, 0);
    endtask

    task automatic t_stream();
        // R5 and R1: FFFF:0000 upward, crossing the 2^20 boundary at offset 0010
        drain(16'hFFFF, 16'h0000, 20, "R5");
    endtask

    task automatic t_redirect();
        lat = 3;
        cs_seg = 16'hFFFF; redirect_ip = 16'h000E; redirect = 1'b1;
        tick();
        redirect = 1'b0;
        chk(ib_valid == 1'b0, "R6", "queue emptied", ib_valid, 0);
        tick();
        chk(mem_req == 1'b1 && mem_addr == 20'hFFFFE, "R6", "restart address", mem_addr, 20'hFFFFE);
        // second redirect while that prefetch is still waiting
        cs_seg = 16'h1000; redirect_ip = 16'hFFFE; redirect = 1'b1;
        tick();
        redirect = 1'b0;
        chk(mem_req == 1'b0, "R6", "in-flight fetch dropped", mem_req, 0);
        chk(ib_valid == 1'b0, "R6", "queue empty again", ib_valid, 0);
        // R3: offset wraps within segment 1000h
        drain(16'h1000, 16'hFFFE, 4, "R3");
        lat = 0;
        cs_seg = 16'hFFFF; redirect_ip = 16'h000E; redirect = 1'b1;
        tick();
        redirect = 1'b0;
        // R1: FFFFE, FFFFF, 00000, 00001
        drain(16'hFFFF, 16'h000E, 4, "R1");
    endtask

    task automatic t_oper(input logic [1:0] sel, input logic [15:0] ofs, input bit we,
                          input logic [7:0] wd, input logic [19:0] exp);
        int pf0;
        bit seen = 1'b0;
        lat = 2;
        redirect_ip = 16'h0000; redirect = 1'b1;
        tick();
        redirect = 1'b0;
        tick();
        tick();
        pf0 = pf_cnt;
        op_sel = sel; op_ofs = ofs; op_we = we; op_wdata = wd; op_req = 1'b1;
        for (int g = 0; g < 50 && !seen; g++) begin
            tick();
            if (mem_req && mem_addr == exp && !mem_ready)
                chk(mem_we == we, "R10", "held write enable", mem_we, we);
            if (op_done) begin
                seen = 1'b1;
                chk(mem_addr == exp, "R7", "operand address", mem_addr, exp);
                chk(mem_we == we, "R9", "operand direction", mem_we, we);
                if (we) chk(mem_wdata == wd, "R9", "write byte", mem_wdata, wd);
                else    chk(op_rdata == pat(exp), "R9", "read byte", op_rdata, pat(exp));
                chk(pf_cnt - pf0 == 1, "R8", "prefetches before operand", pf_cnt - pf0, 1);
            end
        end
        chk(seen, "R9", "op_done seen", seen, 1);
        tick();
        op_req = 1'b0;
        chk(mem_req == 1'b0, "R11", "idle after transfer", mem_req, 0);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_stream();
        t_redirect();
        cs_seg = 16'h1000;
        t_oper(2'd3, 16'h0010, 1'b0, 8'h00, 20'h23460);
        t_oper(2'd0, 16'h1234, 1'b0, 8'h00, 20'hACF04);
        t_oper(2'd2, 16'h0025, 1'b1, 8'h5A, 20'h00015);
        t_oper(2'd1, 16'h00FF, 1'b0, 8'h00, 20'h100FF);
        t_oper(2'd3, 16'hFFFF, 1'b1, 8'hC3, 20'h3344F);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule